// File: doc/BRIEF.md
# Port Fault Qualification Monitor

This block sits beside the power switch of each port of a multi-port power-sourcing controller. It turns two raw comparator flags per port into qualified faults. The first flag says that the gate, sense or output node of the port's switch is at an abnormal voltage, which points to a damaged switch. The second flag says that the port current is below the keep-alive minimum. Both flags are timed against a shared tick strobe. Each port's timing and latched state are separate from every other port's.

A switch-failure condition that holds for a programmable number of consecutive ticks latches a permanent fault. That fault asks for the port to be disabled and selects the reduced gate pull-down strength. Only a per-port reset or a chip reset clears it. An undercurrent that holds for a programmable number of consecutive ticks, while the port is on and disconnect detection is enabled, sets a sticky disconnect event and asks for the port to be turned off. Either of two enable bits turns the undercurrent disconnect on, and both give the same DC behaviour.

Top module: `port_fault_monitor`

## Requirements
- R1: When `abn_volt_i[p]` is high on `FET_QUAL_TICKS` consecutive tick-qualified cycles, `fet_bad_o[p]` goes high at the clock edge that samples the last of those ticks. If `abn_volt_i[p]` is low on any cycle before that, with or without a tick, the count starts again from zero.
- R2: `fet_bad_o[p]` stays high until `port_rst_i[p]` is high at a clock edge or `rst_n` is asserted. If the abnormal condition is still present after such a reset, the fault returns only after another full `FET_QUAL_TICKS` ticks.
- R3: While `fet_bad_o[p]` is high, `disable_req_o[p]` and `weak_pd_o[p]` are high, and `disc_evt_o[p]` cannot become set.
- R4: Stimulus on one port never changes the outputs of any other port.
- R5: When `undercur_i[p]` is high on `DIS_TICKS` consecutive tick-qualified cycles, with the port on and disconnect enabled, `disc_evt_o[p]` goes high at the edge that samples the last of those ticks. It stays high until a port or chip reset, and `disable_req_o[p]` is high while it is set.
- R6: If the current rises above the threshold (`undercur_i[p]` low) before the timer expires, the disconnect count returns to zero, and a later undercurrent needs a full `DIS_TICKS` again.
- R7: With `dc_dis_en_i[p]` and `ac_dis_en_i[p]` both low, no disconnect event is raised. With only `ac_dis_en_i[p]` high, the behaviour is the same as with `dc_dis_en_i[p]` high.
- R8: The disconnect count advances only while `port_on_i[p]` is high. A cycle with the port off returns it to zero.
- R9: After a chip reset, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Chip reset, active low, asynchronous assert |
| tick_i | input | 1 | Timebase strobe, one cycle per tick |
| port_rst_i | input | NUM_PORTS | Per-port reset of latched state and counts |
| abn_volt_i | input | NUM_PORTS | Abnormal switch-node voltage comparator |
| undercur_i | input | NUM_PORTS | Port current below keep-alive minimum |
| dc_dis_en_i | input | NUM_PORTS | DC disconnect enable |
| ac_dis_en_i | input | NUM_PORTS | AC disconnect enable (treated as DC) |
| port_on_i | input | NUM_PORTS | Port power is on |
| disable_req_o | output | NUM_PORTS | Request to turn the port off |
| weak_pd_o | output | NUM_PORTS | Select reduced gate pull-down current |
| fet_bad_o | output | NUM_PORTS | Latched switch-failure fault |
| disc_evt_o | output | NUM_PORTS | Sticky disconnect event |

## Verification
If a qualification count is wrong, the fault or the event edge appears one or more ticks too early or too late. The bench sweeps every hold length around each threshold, so even a one-tick error shows up in the output flags straight after the tick in question. A count that is not cleared on a dropout, or on a port-off cycle, shows up as an early event in the restart sequences. A wrong latch or cross-port coupling shows as a flag that stays set, or that appears on an idle port, on the cycle right after the stimulus.

// File: rtl/pfm_pkg.sv
package pfm_pkg;

  typedef struct packed {
    logic fet_bad;
    logic disc_evt;
  } port_flags_t;

  // Either enable bit selects DC undercurrent disconnect.
  function automatic logic dis_active(input logic dc_en, input logic ac_en);
    return dc_en | ac_en;
  endfunction

endpackage

// File: rtl/pfm_rst_sync.sv
module pfm_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];

endmodule

// File: rtl/pfm_qual_timer.sv
module pfm_qual_timer #(
  parameter int unsigned LIMIT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic run,
  input  logic tick,
  output logic expire
);

  localparam int unsigned CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          at_last;

  assign at_last = (cnt_q == LAST);
  assign expire  = run & tick & at_last & ~clr;

  always_comb begin
    cnt_d = cnt_q;
    if (clr || !run) begin
      cnt_d = '0;
    end else if (tick) begin
      cnt_d = at_last ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/pfm_port_slice.sv
module pfm_port_slice
  import pfm_pkg::*;
#(
  parameter int unsigned FET_QUAL_TICKS = 4,
  parameter int unsigned DIS_TICKS      = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic port_rst,
  input  logic abn_volt,
  input  logic undercur,
  input  logic dc_en,
  input  logic ac_en,
  input  logic port_on,
  output logic disable_req,
  output logic weak_pd,
  output logic fet_bad,
  output logic disc_evt
);

  port_flags_t flags_q, flags_d;
  logic        fet_expire, dis_expire;
  logic        fet_clr, dis_clr, dis_run;

  assign fet_clr = port_rst | flags_q.fet_bad;
  assign dis_clr = port_rst | flags_q.fet_bad | flags_q.disc_evt;
  assign dis_run = undercur & port_on & dis_active(dc_en, ac_en);

  pfm_qual_timer #(.LIMIT(FET_QUAL_TICKS)) u_fet_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (fet_clr),
    .run    (abn_volt),
    .tick   (tick),
    .expire (fet_expire)
  );

  pfm_qual_timer #(.LIMIT(DIS_TICKS)) u_dis_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (dis_clr),
    .run    (dis_run),
    .tick   (tick),
    .expire (dis_expire)
  );

  always_comb begin
    flags_d = flags_q;
    if (port_rst) begin
      flags_d = '0;
    end else begin
      if (fet_expire) flags_d.fet_bad  = 1'b1;
      if (dis_expire) flags_d.disc_evt = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= flags_d;
  end

  assign fet_bad     = flags_q.fet_bad;
  assign disc_evt    = flags_q.disc_evt;
  assign weak_pd     = flags_q.fet_bad;
  assign disable_req = flags_q.fet_bad | flags_q.disc_evt;

endmodule

// File: rtl/port_fault_monitor.sv
module port_fault_monitor #(
  parameter int unsigned NUM_PORTS      = 4,
  parameter int unsigned FET_QUAL_TICKS = 180,
  parameter int unsigned DIS_TICKS      = 300
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick_i,
  input  logic [NUM_PORTS-1:0] port_rst_i,
  input  logic [NUM_PORTS-1:0] abn_volt_i,
  input  logic [NUM_PORTS-1:0] undercur_i,
  input  logic [NUM_PORTS-1:0] dc_dis_en_i,
  input  logic [NUM_PORTS-1:0] ac_dis_en_i,
  input  logic [NUM_PORTS-1:0] port_on_i,
  output logic [NUM_PORTS-1:0] disable_req_o,
  output logic [NUM_PORTS-1:0] weak_pd_o,
  output logic [NUM_PORTS-1:0] fet_bad_o,
  output logic [NUM_PORTS-1:0] disc_evt_o
);

  logic rst_int_n;

  pfm_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    pfm_port_slice #(
      .FET_QUAL_TICKS (FET_QUAL_TICKS),
      .DIS_TICKS      (DIS_TICKS)
    ) u_slice (
      .clk         (clk),
      .rst_n       (rst_int_n),
      .tick        (tick_i),
      .port_rst    (port_rst_i[p]),
      .abn_volt    (abn_volt_i[p]),
      .undercur    (undercur_i[p]),
      .dc_en       (dc_dis_en_i[p]),
      .ac_en       (ac_dis_en_i[p]),
      .port_on     (port_on_i[p]),
      .disable_req (disable_req_o[p]),
      .weak_pd     (weak_pd_o[p]),
      .fet_bad     (fet_bad_o[p]),
      .disc_evt    (disc_evt_o[p])
    );
  end

endmodule

// File: rtl/pfm_checker.sv
module pfm_checker #(
  parameter int unsigned NUM_PORTS = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 tick_i,
  input logic [NUM_PORTS-1:0] port_rst_i,
  input logic [NUM_PORTS-1:0] abn_volt_i,
  input logic [NUM_PORTS-1:0] undercur_i,
  input logic [NUM_PORTS-1:0] dc_dis_en_i,
  input logic [NUM_PORTS-1:0] ac_dis_en_i,
  input logic [NUM_PORTS-1:0] port_on_i,
  input logic [NUM_PORTS-1:0] disable_req_o,
  input logic [NUM_PORTS-1:0] weak_pd_o,
  input logic [NUM_PORTS-1:0] fet_bad_o,
  input logic [NUM_PORTS-1:0] disc_evt_o
);

  for (genvar i = 0; i < NUM_PORTS; i++) begin : g_chk
    AST_FET_NEEDS_CONDITION: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fet_bad_o[i]) |-> $past(abn_volt_i[i] && tick_i)); // R1
    AST_FET_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      fet_bad_o[i] && !port_rst_i[i] |=> fet_bad_o[i]); // R2
    AST_PORT_RESET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      port_rst_i[i] |=> !fet_bad_o[i] && !disc_evt_o[i]); // R2
    AST_NO_DISC_WHEN_BAD: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(disc_evt_o[i]) |-> !$past(fet_bad_o[i])); // R3
    AST_BAD_FORCES_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      fet_bad_o[i] |-> disable_req_o[i] && weak_pd_o[i]); // R3
    AST_DISC_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      disc_evt_o[i] && !port_rst_i[i] |=> disc_evt_o[i]); // R5
    AST_DISC_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(disc_evt_o[i]) |-> $past(dc_dis_en_i[i] || ac_dis_en_i[i])); // R7
    AST_DISC_NEEDS_PORT_ON: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(disc_evt_o[i]) |-> $past(port_on_i[i] && undercur_i[i] && tick_i)); // R8
  end

endmodule

bind port_fault_monitor pfm_checker #(.NUM_PORTS(NUM_PORTS)) u_pfm_checker (
  .clk           (clk),
  .rst_n         (rst_n),
  .tick_i        (tick_i),
  .port_rst_i    (port_rst_i),
  .abn_volt_i    (abn_volt_i),
  .undercur_i    (undercur_i),
  .dc_dis_en_i   (dc_dis_en_i),
  .ac_dis_en_i   (ac_dis_en_i),
  .port_on_i     (port_on_i),
  .disable_req_o (disable_req_o),
  .weak_pd_o     (weak_pd_o),
  .fet_bad_o     (fet_bad_o),
  .disc_evt_o    (disc_evt_o)
);

// File: tb/port_fault_monitor_bench.sv
module port_fault_monitor_bench;

  localparam int CLK_PERIOD = 10;
  localparam int N  = 2;
  localparam int FQ = 4;
  localparam int DQ = 5;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic         rst_n;
  logic         tick;
  logic [N-1:0] port_rst, abn, uc, dc, ac, on;
  logic [N-1:0] dis_req, weak_pd, fet_bad, disc;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  port_fault_monitor #(
    .NUM_PORTS(N), .FET_QUAL_TICKS(FQ), .DIS_TICKS(DQ)
  ) u_port_fault_monitor (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .port_rst_i(port_rst),
    .abn_volt_i(abn), .undercur_i(uc), .dc_dis_en_i(dc), .ac_dis_en_i(ac),
    .port_on_i(on), .disable_req_o(dis_req), .weak_pd_o(weak_pd),
    .fet_bad_o(fet_bad), .disc_evt_o(disc)
  );

  task automatic chk(input string req, input string what,
                     input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk) tick = 1'b1;
      @(negedge clk) tick = 1'b0;
    end
  endtask

  task automatic prst(input logic [N-1:0] m);
    @(negedge clk) port_rst = m;
    @(negedge clk) port_rst = '0;
  endtask

  task automatic chip_reset();
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] m, e;
    rst_n = 1'b0; tick = 1'b0; port_rst = '0;
    abn = '0; uc = '0; dc = '0; ac = '0; on = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R9", "fet_bad", fet_bad, '0);
    chk("R9", "disc_evt", disc, '0);
    chk("R9", "disable_req", dis_req, '0);
    chk("R9", "weak_pd", weak_pd, '0);

    // R1 R3 R4: sweep hold length on each port
    for (int p = 0; p < N; p++) begin
      m = N'(1) << p;
      for (int l = 1; l <= FQ + 1; l++) begin
        prst('1);
        @(negedge clk) abn = m;
        ticks(l);
        e = (l >= FQ) ? m : '0;
        chk("R1", "fet_bad sweep", fet_bad, e);
        chk("R3", "weak_pd", weak_pd, e);
        chk("R3", "disable_req", dis_req, e);
        chk("R4", "disc untouched", disc, '0);
        abn = '0;
      end
    end

    // R1 restart on dropout with a tick, then without a tick
    prst('1);
    abn = 2'b01; ticks(FQ - 1);
    abn = 2'b00; ticks(1);
    abn = 2'b01; ticks(FQ - 1);
    chk("R1", "restart after dropout", fet_bad, 2'b00);
    ticks(1);
    chk("R1", "qualify after restart", fet_bad, 2'b01);
    prst('1);
    abn = 2'b01; ticks(FQ - 1);
    @(negedge clk) abn = 2'b00;
    @(negedge clk) abn = 2'b01;
    ticks(FQ - 1);
    chk("R1", "untimed dropout restart", fet_bad, 2'b00);
    ticks(1);
    chk("R1", "untimed dropout qualify", fet_bad, 2'b01);

    // R2 sticky, port reset, return of fault, chip reset
    abn = 2'b00; ticks(3);
    chk("R2", "sticky after clear", fet_bad, 2'b01);
    abn = 2'b01;
    prst(2'b01);
    chk("R2", "port reset clears", fet_bad, 2'b00);
    ticks(FQ - 1);
    chk("R2", "no early return", fet_bad, 2'b00);
    ticks(1);
    chk("R2", "fault returns", fet_bad, 2'b01);
    abn = 2'b00;
    prst(2'b10);
    chk("R4", "other port reset no effect", fet_bad, 2'b01);
    chip_reset();
    chk("R2", "chip reset clears", fet_bad, 2'b00);

    // R3: disconnect blocked on a faulted port only
    prst('1);
    abn = 2'b01; ticks(FQ);
    abn = 2'b00;
    uc = 2'b11; on = 2'b11; dc = 2'b11;
    ticks(DQ + 2);
    chk("R3", "no disc while bad", disc, 2'b10);
    chk("R3", "disable_req both", dis_req, 2'b11);
    chk("R3", "weak_pd faulted only", weak_pd, 2'b01);
    uc = '0; on = '0; dc = '0;

    // R5 R7 R8 sweep of enables, port-on and hold length
    for (int p = 0; p < N; p++) begin
      m = N'(1) << p;
      for (int en = 0; en < 4; en++) begin
        for (int po = 0; po < 2; po++) begin
          for (int l = 1; l <= DQ + 1; l++) begin
            prst('1);
            dc = en[0] ? m : '0;
            ac = en[1] ? m : '0;
            on = (po != 0) ? m : '0;
            uc = m;
            ticks(l);
            e = (en != 0 && po != 0 && l >= DQ) ? m : '0;
            if (en == 0 || en == 2)
              chk("R7", "disc enable mode", disc, e);
            else if (po == 0)
              chk("R8", "disc port off", disc, e);
            else
              chk("R5", "disc sweep", disc, e);
            chk("R5", "disable_req", dis_req, e);
            chk("R4", "fet untouched", fet_bad, '0);
            uc = '0;
          end
        end
      end
    end

    // R5 sticky
    prst('1);
    dc = 2'b01; on = 2'b01; uc = 2'b01;
    ticks(DQ);
    uc = 2'b00; ticks(3);
    chk("R5", "disc sticky", disc, 2'b01);
    prst(2'b01);
    chk("R5", "port reset clears disc", disc, 2'b00);

    // R6 restart on current return
    uc = 2'b01; ticks(DQ - 1);
    uc = 2'b00; ticks(1);
    uc = 2'b01; ticks(DQ - 1);
    chk("R6", "restart after current return", disc, 2'b00);
    ticks(1);
    chk("R6", "qualify after restart", disc, 2'b01);

    // R8 port-off cycle clears the count
    prst('1);
    uc = 2'b01; ticks(DQ - 1);
    @(negedge clk) on = 2'b00;
    @(negedge clk) on = 2'b01;
    ticks(DQ - 1);
    chk("R8", "port off restarts count", disc, 2'b00);
    ticks(1);
    chk("R8", "qualify after port on", disc, 2'b01);
    uc = '0; on = '0; dc = '0;

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule